// File: doc/BRIEF.md
# Serial Peripheral Slave with Threshold-Interrupt FIFOs

This block is the slave end of a four-wire serial peripheral link. An external master supplies the serial clock and an active-low select. While select is low, the block shifts a character out on its data output and captures a character from its data input on every clock cycle. Outgoing characters come from a transmit FIFO. Received characters go into a receive FIFO. Both FIFOs are filled and drained by software through a small register port that runs on the system clock.

Software sets the character length, from 1 to 16 bits. It sets a fill threshold for each FIFO and chooses which interrupts are enabled. Two interrupt outputs tell software when the transmit FIFO needs refilling and when the receive FIFO holds enough data. If the FIFOs are turned off, each one acts as a single-word buffer. In that mode only one combined interrupt remains, and it is raised for a received character or for an overrun.

Every character shorter than 16 bits occupies the upper bits of its 16-bit word, in both directions. Every word written takes one FIFO entry, whatever the character length.

Top module: `spi_slave_fifo`

## Requirements
- R1: Each FIFO holds up to 16 words of 16 bits. Every write to TXDATA (address 3) takes one whole entry, whatever the character length. A write made while the transmit FIFO is full is dropped, and the fill count stays at 16.
- R2: Transmit data is left-justified and sent MSB first. With an 8-bit character (CTRL bits [3:0] = length minus 1 = 7), the word 0xA500 goes out as 0xA5. CTRL bit 4 enables the FIFOs.
- R3: A received character is stored left-justified in its word and read by popping RXDATA (address 4). For example, 8 bits of 0x5A read back as 0x5A00.
- R4: The transmit flag (TXCTL bit 6) sets whenever the transmit fill (TXCTL [12:8]) is at or below the transmit level (TXCTL [4:0]). The flag stays set until it is cleared. tx_irq_o is high only when the flag is set, TXCTL bit 5 (enable) is 1 and the FIFOs are enabled.
- R5: The receive flag (RXCTL bit 6) sets whenever the receive fill (RXCTL [12:8]) is at or above the receive level (RXCTL [4:0]). In FIFO mode, rx_irq_o equals the flag AND RXCTL bit 5.
- R6: Writing 1 to bit 6 of TXCTL or RXCTL clears that flag. If the threshold condition still holds, the flag sets again one cycle later.
- R7: Writing 1 to bit 7 of TXCTL or RXCTL empties that FIFO and sets its fill count to 0.
- R8: A character that starts while the transmit FIFO is empty is sent as all zeros.
- R9: A character that completes while the receive FIFO is full is dropped, and the overrun flag (RXCTL bit 13) sets. Writing 1 to RXCTL bit 8 clears the overrun flag. Data already stored is not disturbed.
- R10: With the FIFOs disabled (CTRL bit 4 = 0), each FIFO holds one word and tx_irq_o stays low. rx_irq_o is then (receive buffer not empty AND CTRL bit 6) OR (overrun AND CTRL bit 5).
- R11: Shifting follows clock polarity 0 with phase 1. The slave drives data on the rising clock edge and samples on the falling edge, only while cs_ni is low. Raising cs_ni in the middle of a character discards the partial character. The next character then starts from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register address: 0 CTRL, 1 TXCTL, 2 RXCTL, 3 TXDATA, 4 RXDATA |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data (combinational) |
| sclk_i | input | 1 | Serial clock from the master |
| cs_ni | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| tx_irq_o | output | 1 | Transmit threshold interrupt |
| rx_irq_o | output | 1 | Receive threshold interrupt, or the combined interrupt in non-FIFO mode |

## Verification
Faults in the FIFO pointers or the fill counts show up at the ports within the same character. The master sees the wrong word or a repeated word on miso_o, or RXDATA returns a stale value. A wrong threshold comparison or flag register appears on tx_irq_o or rx_irq_o about two system clocks after the fill count crosses the level. A stuck bit counter misaligns the very next character, so aborted transfers and changes of character length are followed at once by a full transfer whose data is checked.

// File: rtl/spis_pkg.sv
package spis_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_TXCTL = 3'd1,
    A_RXCTL = 3'd2,
    A_TXDAT = 3'd3,
    A_RXDAT = 3'd4
  } spis_addr_e;

  // CTRL fields
  localparam int unsigned B_FIFO_EN = 4;
  localparam int unsigned B_OVR_IE  = 5;
  localparam int unsigned B_XFER_IE = 6;
  // TXCTL / RXCTL fields
  localparam int unsigned B_IE      = 5;
  localparam int unsigned B_FLAG    = 6;
  localparam int unsigned B_FRST    = 7;
  localparam int unsigned B_OVR_CLR = 8;
  localparam int unsigned CNT_LSB   = 8;
  localparam int unsigned B_OVR     = 13;
endpackage

// File: rtl/spis_fifo.sv
module spis_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [CW-1:0] cap_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q >= cap_i);
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign count_o = cnt_q;
  assign rdata_o = empty_o ? '0 : mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wp_q] <= wdata_i;
  end
endmodule

// File: rtl/spis_shifter.sv
module spis_shifter #(
  parameter int unsigned DW = 16,
  localparam int unsigned LW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  input  logic [LW-1:0] len_m1_i,
  input  logic [DW-1:0] tx_word_i,
  input  logic          tx_empty_i,
  output logic          tx_pop_o,
  output logic          rx_push_o,
  output logic [DW-1:0] rx_word_o,
  output logic          miso_o
);
  logic [1:0] sclk_s, cs_s, mosi_s;
  logic sclk_d;
  logic rise, fall, active, last_bit;
  logic [LW-1:0] bit_q;
  logic [DW-1:0] sh_q, rx_q, rx_next;
  logic [LW-1:0] pad;
  logic miso_q, push_q;
  logic [DW-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_s <= {sclk_s[0], sclk_i};
      cs_s   <= {cs_s[0], cs_ni};
      mosi_s <= {mosi_s[0], mosi_i};
      sclk_d <= sclk_s[1];
    end
  end

  assign active   = ~cs_s[1];
  assign rise     = sclk_s[1] & ~sclk_d;
  assign fall     = ~sclk_s[1] & sclk_d;
  assign last_bit = (bit_q == len_m1_i);
  assign rx_next  = {rx_q[DW-2:0], mosi_s[1]};
  assign pad      = LW'(DW - 1) - len_m1_i;
  assign tx_pop_o = active & rise & (bit_q == '0) & ~tx_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      miso_q <= 1'b0;
      push_q <= 1'b0;
      word_q <= '0;
    end else begin
      push_q <= 1'b0;
      if (!active) begin
        bit_q  <= '0;
        miso_q <= 1'b0;
      end else if (rise) begin
        // drive on the leading edge; a new character loads at bit 0
        if (bit_q == '0) begin
          sh_q   <= tx_empty_i ? '0 : tx_word_i;
          miso_q <= tx_empty_i ? 1'b0 : tx_word_i[DW-1];
        end else begin
          sh_q   <= sh_q << 1;
          miso_q <= sh_q[DW-2];
        end
      end else if (fall) begin
        rx_q <= rx_next;
        if (last_bit) begin
          bit_q  <= '0;
          push_q <= 1'b1;
          word_q <= rx_next << pad;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign miso_o    = miso_q;
  assign rx_push_o = push_q;
  assign rx_word_o = word_q;
endmodule

// File: rtl/spis_level_flag.sv
module spis_level_flag #(
  parameter int unsigned CW  = 5,
  parameter bit          AT_OR_ABOVE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] level_i,
  input  logic          clr_i,
  output logic          flag_o
);
  logic hit, flag_q;

  generate
    if (AT_OR_ABOVE) begin : g_ge
      assign hit = (count_i >= level_i);
    end else begin : g_le
      assign hit = (count_i <= level_i);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (clr_i)  flag_q <= 1'b0;
    else             flag_q <= flag_q | hit;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/spi_slave_fifo.sv
module spi_slave_fifo
  import spis_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              tx_irq_o,
  output logic              rx_irq_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned LW = $clog2(DATA_W);

  logic [LW-1:0] len_m1_q;
  logic fifo_en_q, ovr_ie_q, xfer_ie_q;
  logic [CW-1:0] tx_lvl_q, rx_lvl_q;
  logic tx_ie_q, rx_ie_q, ovr_q;

  logic wr, rd;
  logic tx_clr, tx_rst, rx_clr, rx_rst, ovr_clr;
  logic host_push, host_pop;
  logic [CW-1:0] cap, tx_cnt, rx_cnt;
  logic [DATA_W-1:0] tx_head, rx_head, rx_word;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_pop, rx_push, tx_flag, rx_flag;
  logic unused_wdata;

  assign wr = reg_en_i & reg_we_i;
  assign rd = reg_en_i & ~reg_we_i;
  assign tx_clr    = wr && (reg_addr_i == A_TXCTL) && reg_wdata_i[B_FLAG];
  assign tx_rst    = wr && (reg_addr_i == A_TXCTL) && reg_wdata_i[B_FRST];
  assign rx_clr    = wr && (reg_addr_i == A_RXCTL) && reg_wdata_i[B_FLAG];
  assign rx_rst    = wr && (reg_addr_i == A_RXCTL) && reg_wdata_i[B_FRST];
  assign ovr_clr   = wr && (reg_addr_i == A_RXCTL) && reg_wdata_i[B_OVR_CLR];
  assign host_push = wr && (reg_addr_i == A_TXDAT);
  assign host_pop  = rd && (reg_addr_i == A_RXDAT);
  assign cap       = fifo_en_q ? CW'(DEPTH) : CW'(1);
  assign unused_wdata = ^reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_m1_q  <= LW'(DATA_W - 1);
      fifo_en_q <= 1'b1;
      ovr_ie_q  <= 1'b0;
      xfer_ie_q <= 1'b0;
      tx_lvl_q  <= '0;
      tx_ie_q   <= 1'b0;
      rx_lvl_q  <= CW'(DEPTH);
      rx_ie_q   <= 1'b0;
    end else if (wr) begin
      case (reg_addr_i)
        A_CTRL: begin
          len_m1_q  <= reg_wdata_i[LW-1:0];
          fifo_en_q <= reg_wdata_i[B_FIFO_EN];
          ovr_ie_q  <= reg_wdata_i[B_OVR_IE];
          xfer_ie_q <= reg_wdata_i[B_XFER_IE];
        end
        A_TXCTL: begin
          tx_lvl_q <= reg_wdata_i[CW-1:0];
          tx_ie_q  <= reg_wdata_i[B_IE];
        end
        A_RXCTL: begin
          rx_lvl_q <= reg_wdata_i[CW-1:0];
          rx_ie_q  <= reg_wdata_i[B_IE];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovr_q <= 1'b0;
    else if (ovr_clr)            ovr_q <= 1'b0;
    else if (rx_push && rx_full) ovr_q <= 1'b1;
  end

  spis_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(tx_rst), .cap_i(cap),
    .push_i(host_push), .wdata_i(reg_wdata_i), .pop_i(tx_pop),
    .rdata_o(tx_head), .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  spis_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(rx_rst), .cap_i(cap),
    .push_i(rx_push), .wdata_i(rx_word), .pop_i(host_pop),
    .rdata_o(rx_head), .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  spis_shifter #(.DW(DATA_W)) u_shift (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .len_m1_i(len_m1_q), .tx_word_i(tx_head), .tx_empty_i(tx_empty),
    .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_word_o(rx_word), .miso_o
  );

  spis_level_flag #(.CW(CW), .AT_OR_ABOVE(1'b0)) u_tx_flag (
    .clk_i, .rst_ni, .count_i(tx_cnt), .level_i(tx_lvl_q),
    .clr_i(tx_clr), .flag_o(tx_flag)
  );

  spis_level_flag #(.CW(CW), .AT_OR_ABOVE(1'b1)) u_rx_flag (
    .clk_i, .rst_ni, .count_i(rx_cnt), .level_i(rx_lvl_q),
    .clr_i(rx_clr), .flag_o(rx_flag)
  );

  assign tx_irq_o = fifo_en_q & tx_ie_q & tx_flag;
  assign rx_irq_o = fifo_en_q ? (rx_ie_q & rx_flag)
                              : ((xfer_ie_q & ~rx_empty) | (ovr_ie_q & ovr_q));

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[LW-1:0]     = len_m1_q;
        reg_rdata_o[B_FIFO_EN]  = fifo_en_q;
        reg_rdata_o[B_OVR_IE]   = ovr_ie_q;
        reg_rdata_o[B_XFER_IE]  = xfer_ie_q;
      end
      A_TXCTL: begin
        reg_rdata_o[CW-1:0]         = tx_lvl_q;
        reg_rdata_o[B_IE]           = tx_ie_q;
        reg_rdata_o[B_FLAG]         = tx_flag;
        reg_rdata_o[CNT_LSB +: CW]  = tx_cnt;
      end
      A_RXCTL: begin
        reg_rdata_o[CW-1:0]         = rx_lvl_q;
        reg_rdata_o[B_IE]           = rx_ie_q;
        reg_rdata_o[B_FLAG]         = rx_flag;
        reg_rdata_o[CNT_LSB +: CW]  = rx_cnt;
        reg_rdata_o[B_OVR]          = ovr_q;
      end
      A_RXDAT: reg_rdata_o = rx_head;
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spis_checker.sv
module spis_checker #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_en,
  input logic          tx_irq,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] tx_lvl,
  input logic          tx_clr,
  input logic          tx_flag,
  input logic [CW-1:0] rx_cnt,
  input logic          rx_push,
  input logic          rx_full,
  input logic          ovr,
  input logic          ovr_clr
);
  p_tx_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= CW'(DEPTH));

  p_rx_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= CW'(DEPTH));

  p_tx_flag_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt <= tx_lvl && !tx_clr) |=> tx_flag);

  p_flag_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_clr |=> !tx_flag);

  p_overrun_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && rx_full && !ovr_clr) |=> ovr);

  p_no_tx_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en |-> !tx_irq);
endmodule

bind spi_slave_fifo spis_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .fifo_en (fifo_en_q),
  .tx_irq  (tx_irq_o),
  .tx_cnt  (tx_cnt),
  .tx_lvl  (tx_lvl_q),
  .tx_clr  (tx_clr),
  .tx_flag (tx_flag),
  .rx_cnt  (rx_cnt),
  .rx_push (rx_push),
  .rx_full (rx_full),
  .ovr     (ovr_q),
  .ovr_clr (ovr_clr)
);

// File: tb/tb_spi_slave_fifo.sv
module tb_spi_slave_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, tx_irq, rx_irq;
  int total = 0;
  int bad = 0;

  always #10ns clk = ~clk;

  spi_slave_fifo dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi), .miso_o(miso),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1ns d = reg_rdata;
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  task automatic xfer(input int n, input logic [15:0] mout, output logic [15:0] min);
    logic [15:0] acc = '0;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; mosi = mout[15-i];
      repeat (8) @(negedge clk);
      acc = {acc[14:0], miso};
      sclk = 1'b0;
      repeat (8) @(negedge clk);
    end
    min = acc << (16 - n);
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R4 reset tx_irq", {15'd0, tx_irq}, 16'd0);
    chk("R5 reset rx_irq", {15'd0, rx_irq}, 16'd0);
    chk("R11 reset miso", {15'd0, miso}, 16'd0);
    rd(3'd0, d); chk("R2 reset CTRL", d, 16'h001F);
    rd(3'd1, d); chk("R4 reset TXCTL flag set on empty", d, 16'h0040);
    rd(3'd2, d); chk("R5 reset RXCTL", d, 16'h0010);
  endtask

  task automatic t_tx_level();
    logic [15:0] d;
    wr(3'd1, 16'h0024); settle();
    chk("R4 empty fifo irq", {15'd0, tx_irq}, 16'd1);
    for (int i = 0; i < 5; i++) wr(3'd3, 16'h1100 + 16'(i));
    wr(3'd1, 16'h0064); settle();
    chk("R6 cleared above level", {15'd0, tx_irq}, 16'd0);
    rd(3'd1, d); chk("R4 TXCTL after clear", d, 16'h0524);
    wr(3'd1, 16'h0068); settle();
    chk("R6 flag resets when condition holds", {15'd0, tx_irq}, 16'd1);
  endtask

  task automatic t_fill();
    logic [15:0] d;
    for (int i = 0; i < 12; i++) wr(3'd3, 16'h2200 + 16'(i));
    settle();
    rd(3'd1, d); chk("R1 full count capped", (d >> 8) & 16'h1F, 16'd16);
    wr(3'd1, 16'h0088); settle();
    rd(3'd1, d); chk("R7 tx fifo reset", (d >> 8) & 16'h1F, 16'd0);
    chk("R4 irq needs enable", {15'd0, tx_irq}, 16'd0);
  endtask

  task automatic t_shift();
    logic [15:0] m, d;
    wr(3'd0, 16'h0017);
    wr(3'd3, 16'hA500); wr(3'd3, 16'h3C00);
    xfer(8, 16'h5A00, m);
    chk("R2 8-bit tx left-justified", m, 16'hA500);
    rd(3'd4, d); chk("R3 8-bit rx left-justified", d, 16'h5A00);
    xfer(8, 16'hC300, m);
    chk("R2 second word", m, 16'h3C00);
    rd(3'd4, d); chk("R3 second rx", d, 16'hC300);
    xfer(8, 16'h8100, m);
    chk("R8 empty fifo sends zeros", m, 16'h0000);
    rd(3'd4, d); chk("R3 rx with empty tx", d, 16'h8100);
    wr(3'd0, 16'h0013);
    wr(3'd3, 16'h9000);
    xfer(4, 16'h6000, m);
    chk("R2 4-bit tx", m, 16'h9000);
    rd(3'd4, d); chk("R3 4-bit rx", d, 16'h6000);
    for (int i = 0; i < 6; i++) wr(3'd3, 16'h1000);
    settle();
    rd(3'd1, d); chk("R1 six short chars six entries", (d >> 8) & 16'h1F, 16'd6);
    wr(3'd1, 16'h0088);
    wr(3'd0, 16'h001F);
    wr(3'd3, 16'hBEEF);
    xfer(16, 16'h1234, m);
    chk("R2 16-bit tx", m, 16'hBEEF);
    rd(3'd4, d); chk("R3 16-bit rx", d, 16'h1234);
  endtask

  task automatic t_rx_level();
    logic [15:0] m, d;
    wr(3'd0, 16'h0017);
    wr(3'd2, 16'h0022);
    xfer(8, 16'h1100, m); settle();
    chk("R5 below level", {15'd0, rx_irq}, 16'd0);
    xfer(8, 16'h2200, m); settle();
    chk("R5 at level", {15'd0, rx_irq}, 16'd1);
    rd(3'd4, d); chk("R3 rx order first", d, 16'h1100);
    settle();
    chk("R5 flag sticky", {15'd0, rx_irq}, 16'd1);
    wr(3'd2, 16'h0062); settle();
    chk("R6 rx clear below level", {15'd0, rx_irq}, 16'd0);
    rd(3'd4, d); chk("R3 rx order second", d, 16'h2200);
  endtask

  task automatic t_overrun();
    logic [15:0] m, d;
    wr(3'd2, 16'h0010);
    wr(3'd0, 16'h0013);
    for (int i = 0; i < 16; i++) xfer(4, 16'(i) << 12, m);
    rd(3'd2, d);
    chk("R9 full no overrun", (d >> 13) & 16'h1, 16'd0);
    chk("R1 rx full count", (d >> 8) & 16'h1F, 16'd16);
    xfer(4, 16'h5000, m);
    rd(3'd2, d);
    chk("R9 overrun flag", (d >> 13) & 16'h1, 16'd1);
    chk("R9 count unchanged", (d >> 8) & 16'h1F, 16'd16);
    rd(3'd4, d); chk("R9 data intact 0", d, 16'h0000);
    rd(3'd4, d); chk("R9 data intact 1", d, 16'h1000);
    wr(3'd2, 16'h0110);
    rd(3'd2, d); chk("R9 overrun cleared", (d >> 13) & 16'h1, 16'd0);
    wr(3'd2, 16'h0090);
    rd(3'd2, d); chk("R7 rx fifo reset", (d >> 8) & 16'h1F, 16'd0);
  endtask

  task automatic t_nofifo();
    logic [15:0] m, d;
    wr(3'd0, 16'h0067);
    wr(3'd1, 16'h0028); settle();
    chk("R10 no tx irq", {15'd0, tx_irq}, 16'd0);
    chk("R10 idle combined irq", {15'd0, rx_irq}, 16'd0);
    wr(3'd3, 16'h7700); wr(3'd3, 16'h6600); settle();
    rd(3'd1, d); chk("R10 single word buffer", (d >> 8) & 16'h1F, 16'd1);
    xfer(8, 16'h4400, m);
    chk("R10 tx data", m, 16'h7700);
    chk("R10 irq on receive", {15'd0, rx_irq}, 16'd1);
    xfer(8, 16'h5500, m);
    rd(3'd4, d); chk("R10 overrun keeps first", d, 16'h4400);
    settle();
    chk("R10 irq held by overrun", {15'd0, rx_irq}, 16'd1);
    wr(3'd2, 16'h0110); settle();
    chk("R10 irq drops after clear", {15'd0, rx_irq}, 16'd0);
    wr(3'd0, 16'h0017);
    wr(3'd1, 16'h0080);
  endtask

  task automatic t_abort();
    logic [15:0] m, d;
    wr(3'd3, 16'h9600);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b1; mosi = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
      repeat (8) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    rd(3'd2, d); chk("R11 partial char dropped", (d >> 8) & 16'h1F, 16'd0);
    wr(3'd3, 16'h3300);
    xfer(8, 16'h6900, m);
    chk("R11 realigned tx", m, 16'h3300);
    rd(3'd4, d); chk("R11 realigned rx", d, 16'h6900);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_tx_level();
    t_fill();
    t_shift();
    t_rx_level();
    t_overrun();
    t_nofifo();
    t_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule